// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Set/Clear Access

This block gathers up to sixteen level-sensitive interrupt sources from a board and merges them into one registered interrupt line toward a host processor. Each source passes through three per-bit registers. An enable register decides whether a high source latches. A pending register holds latched sources until software acknowledges them. A mask-state register decides whether a pending bit may drive the combined line.

Software reaches the block through a simple synchronous register bus with 16-bit data. Registers sit on a 32-bit stride. Every change to enable, mask or pending goes through a dedicated write-one access point, so only the bits written as one are affected. Software never has to read a register before changing it. A read-only priority word gives the index of the lowest-numbered source that is both pending and unmasked. This index is the one that software services first.

Top module: `irq_casc_top`

## Requirements
- R1: After the active-low synchronous reset `rstN`, the enable, pending and mask-state registers are all zero, `irqOut` is 0 and every readable offset returns 0.
- R2: Offsets are byte addresses on a 4-byte stride. 0x00 is pending (read) and acknowledge (write). 0x04 and 0x08 set and clear enable. 0x0C and 0x10 set and clear mask state. 0x14 is the priority word. Reads of any other address return 0, and writes to any other address, including misaligned ones, change nothing.
- R3: Writing to 0x04 sets the enable bits written as one, and writing to 0x08 clears them. Zero bits have no effect. Both offsets read back the enable register.
- R4: Writing to 0x0C sets the mask-state bits written as one, which unmasks those sources. Writing to 0x10 clears them, which masks those sources. Zero bits have no effect. Both offsets read the mask state, where 1 means unmasked.
- R5: A pending bit sets at the first clock edge where its source is high while its enable bit is already 1. It stays set after the source falls. A source whose enable bit is 0 never becomes pending.
- R6: Writing ones to 0x00 clears those pending bits, and zero bits are ignored. The acknowledge wins over a source that is high in the same cycle. If the source is still high, the bit sets again on the next edge.
- R7: `irqOut` is a register that equals the OR of (pending AND mask state) as sampled at the previous clock edge. It therefore follows a pending or mask change one cycle later.
- R8: Reading 0x14 returns 0 when no bit is both pending and unmasked. Otherwise bit 15 is 1 and bits 3:0 hold the lowest index that is pending and unmasked, so lower index means higher priority.
- R9: The start-up sequence writes 0xFFFF to 0x10, then to 0x04, then to 0x00. With all sources low, this leaves every source enabled, every source masked, nothing pending and `irqOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address during a read |
| srcIn | input | 16 | Level-sensitive interrupt sources, synchronous to clk |
| irqOut | output | 1 | Combined registered interrupt toward the host |

## Verification
The hardest case to reach from the ports is the one where an acknowledge and a still-high source hit the same pending bit in the same cycle. The bench holds the source high, issues the acknowledge write, and reads pending in the half cycle before the next edge to see the clear win. It then reads again one edge later to see the bit re-arm. The one-cycle lag of `irqOut` is caught by sampling it both right after a pending or mask change and one edge later. Priority is swept over rotated source and mask patterns, with the expected lowest index computed in the bench.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;

  // Byte offsets on a 4-byte stride
  localparam int OFS_PEND     = 0;
  localparam int OFS_EN_SET   = 4;
  localparam int OFS_EN_CLR   = 8;
  localparam int OFS_MASK_SET = 12;
  localparam int OFS_MASK_CLR = 16;
  localparam int OFS_PRIO     = 20;

  typedef struct packed {
    logic ack;
    logic enSet;
    logic enClr;
    logic mkSet;
    logic mkClr;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PEND,
    RD_ENABLE,
    RD_MASK,
    RD_PRIO
  } rdSel_e;

endpackage

// File: rtl/irq_casc_ctrl.sv
module irq_casc_ctrl
  import irq_casc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         strobe,
  output rdSel_e            rdSel
);

  logic doWrite;
  logic doRead;

  assign doWrite = busSel && busWr;
  assign doRead  = busSel && !busWr;

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_PEND): begin
        strobe.ack = doWrite;
        if (doRead) rdSel = RD_PEND;
      end
      ADDR_W'(OFS_EN_SET): begin
        strobe.enSet = doWrite;
        if (doRead) rdSel = RD_ENABLE;
      end
      ADDR_W'(OFS_EN_CLR): begin
        strobe.enClr = doWrite;
        if (doRead) rdSel = RD_ENABLE;
      end
      ADDR_W'(OFS_MASK_SET): begin
        strobe.mkSet = doWrite;
        if (doRead) rdSel = RD_MASK;
      end
      ADDR_W'(OFS_MASK_CLR): begin
        strobe.mkClr = doWrite;
        if (doRead) rdSel = RD_MASK;
      end
      ADDR_W'(OFS_PRIO): begin
        if (doRead) rdSel = RD_PRIO;
      end
      default: begin
        strobe = '0;
        rdSel  = RD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/irq_casc_dp.sv
module irq_casc_dp
  import irq_casc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  wrStrobe_t          strobe,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  wData,
  output logic [DATA_W-1:0]  rData,
  output logic               irqOut
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] wBits;
  logic [NUM_SRC-1:0] ackBits;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_SRC-1:0] actv;
  logic [IDX_W-1:0]   prioIdx;
  logic               prioFound;

  assign wBits   = wData[NUM_SRC-1:0];
  assign ackBits = strobe.ack ? wBits : '0;

  // Set then clear, so a clear reaching the same bit wins
  always_comb begin
    enNext   = (enReg   | (strobe.enSet ? wBits : '0)) & ~(strobe.enClr ? wBits : '0);
    maskNext = (maskReg | (strobe.mkSet ? wBits : '0)) & ~(strobe.mkClr ? wBits : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      maskReg <= '0;
    end else begin
      enReg   <= enNext;
      maskReg <= maskNext;
    end
  end

  // One latch cell per source; acknowledge beats a simultaneous set
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (!rstN)                    pendReg[g] <= 1'b0;
      else if (ackBits[g])          pendReg[g] <= 1'b0;
      else if (srcIn[g] && enReg[g]) pendReg[g] <= 1'b1;
    end
  end

  assign actv = pendReg & maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |actv;
  end

  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    prioIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (actv[i]) prioIdx = IDX_W'(i);
    end
    prioFound = |actv;
  end

  always_comb begin
    rData = '0;
    case (rdSel)
      RD_PEND:   rData = DATA_W'(pendReg);
      RD_ENABLE: rData = DATA_W'(enReg);
      RD_MASK:   rData = DATA_W'(maskReg);
      RD_PRIO: begin
        rData[IDX_W-1:0] = prioIdx;
        rData[DATA_W-1]  = prioFound;
      end
      default:   rData = '0;
    endcase
  end

  // R3: enable moves only on an enable strobe
  p_en_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.enSet || strobe.enClr) |=> $stable(enReg));

  // R4: mask moves only on a mask strobe
  p_mask_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.mkSet || strobe.mkClr) |=> $stable(maskReg));

  // R5: no new pending bit without an enabled high source
  p_pend_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendReg & ~$past(pendReg) & ~$past(srcIn & enReg)) == '0));

  // R5: a pending bit only falls through an acknowledge
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~pendReg & $past(pendReg) & ~$past(ackBits)) == '0));

  // R6: acknowledged bits are clear after the edge
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ack |=> ((pendReg & $past(wBits)) == '0));

  // R7: combined line rises or falls one cycle after the active set
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|actv));
  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> !$past(|actv));

  // R8: reported index is active and nothing below it is
  p_prio_lowest_r8: assert property (@(posedge clk) disable iff (!rstN)
    prioFound |-> (actv[prioIdx] &&
                   ((actv & ((NUM_SRC'(1) << prioIdx) - NUM_SRC'(1))) == '0)));

endmodule

// File: rtl/irq_casc_top.sv
module irq_casc_top
  import irq_casc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  wrStrobe_t strobe;
  rdSel_e    rdSel;

  irq_casc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irq_casc_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wData  (busWdata),
    .rData  (busRdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/irq_casc_top_tb.sv
module irq_casc_top_tb;

  localparam logic [5:0] A_PEND = 6'd0,  A_ENS = 6'd4,  A_ENC = 6'd8;
  localparam logic [5:0] A_MKS  = 6'd12, A_MKC = 6'd16, A_PRIO = 6'd20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] srcIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_casc_top u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [15:0] lowest(input logic [15:0] v);
    logic [15:0] r = 16'h0000;
    for (int j = 15; j >= 0; j--) if (v[j]) r = 16'h8000 | 16'(j);
    return r;
  endfunction

  function automatic bit mapped(input logic [5:0] a);
    return a == A_PEND || a == A_ENS || a == A_ENC || a == A_MKS || a == A_MKC || a == A_PRIO;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    finishRun();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] pat;
    logic [15:0] msk;
    repeat (3) tick();
    // R1 reset state
    rd(A_PEND, d); chk("R1 pending", d, 16'h0);
    rd(A_ENS, d);  chk("R1 enable", d, 16'h0);
    rd(A_MKS, d);  chk("R1 mask", d, 16'h0);
    rd(A_PRIO, d); chk("R1 prio", d, 16'h0);
    chk("R1 irqOut", {15'h0, irqOut}, 16'h0);
    rstN = 1'b1;
    tick();

    // R9 start-up sequence
    wr(A_MKC, 16'hFFFF); wr(A_ENS, 16'hFFFF); wr(A_PEND, 16'hFFFF);
    rd(A_ENC, d);  chk("R9 enable", d, 16'hFFFF);
    rd(A_MKC, d);  chk("R9 mask", d, 16'h0000);
    rd(A_PEND, d); chk("R9 pending", d, 16'h0000);
    tick();
    chk("R9 irqOut", {15'h0, irqOut}, 16'h0);

    // R2 unmapped and misaligned addresses
    for (int a = 0; a < 64; a++) begin
      if (!mapped(6'(a))) begin
        wr(6'(a), 16'hFFFF);
        rd(6'(a), d); chk("R2 unmapped read", d, 16'h0);
      end
    end
    rd(A_ENS, d);  chk("R2 enable untouched", d, 16'hFFFF);
    rd(A_MKS, d);  chk("R2 mask untouched", d, 16'h0000);
    rd(A_PEND, d); chk("R2 pending untouched", d, 16'h0000);

    // R3 enable set/clear
    wr(A_ENC, 16'h00FF); rd(A_ENS, d); chk("R3 clear", d, 16'hFF00);
    wr(A_ENC, 16'h0000); rd(A_ENC, d); chk("R3 zero clear", d, 16'hFF00);
    wr(A_ENS, 16'h0003); rd(A_ENC, d); chk("R3 set", d, 16'hFF03);
    wr(A_ENS, 16'h0000); rd(A_ENS, d); chk("R3 zero set", d, 16'hFF03);
    wr(A_ENS, 16'hFFFF);

    // R4 mask set/clear
    wr(A_MKS, 16'h8001); rd(A_MKC, d); chk("R4 unmask", d, 16'h8001);
    wr(A_MKS, 16'h0000); rd(A_MKS, d); chk("R4 zero set", d, 16'h8001);
    wr(A_MKC, 16'h0001); rd(A_MKS, d); chk("R4 mask", d, 16'h8000);
    wr(A_MKC, 16'h0000); rd(A_MKC, d); chk("R4 zero clear", d, 16'h8000);
    wr(A_MKC, 16'hFFFF);

    // R5 R7 R8 per-source sweep
    for (int i = 0; i < 16; i++) begin
      srcIn = 16'(1) << i;
      tick();
      rd(A_PEND, d); chk("R5 latch", d, 16'(1) << i);
      srcIn = '0;
      tick();
      rd(A_PEND, d); chk("R5 hold after fall", d, 16'(1) << i);
      chk("R7 masked low", {15'h0, irqOut}, 16'h0);
      wr(A_MKS, 16'(1) << i);
      chk("R7 lag on unmask", {15'h0, irqOut}, 16'h0);
      tick();
      chk("R7 asserted", {15'h0, irqOut}, 16'h1);
      rd(A_PRIO, d); chk("R8 single", d, 16'h8000 | 16'(i));
      wr(A_PEND, 16'(1) << i);
      rd(A_PEND, d); chk("R6 ack", d, 16'h0);
      chk("R7 lag on ack", {15'h0, irqOut}, 16'h1);
      tick();
      chk("R7 deasserted", {15'h0, irqOut}, 16'h0);
      wr(A_MKC, 16'(1) << i);
    end

    // R5 disabled source never pends; enable takes effect next edge
    wr(A_ENC, 16'h0010);
    srcIn = 16'h0010;
    repeat (3) tick();
    rd(A_PEND, d); chk("R5 disabled", d, 16'h0);
    wr(A_ENS, 16'h0010);
    rd(A_PEND, d); chk("R5 enable lag", d, 16'h0);
    tick();
    rd(A_PEND, d); chk("R5 enabled latch", d, 16'h0010);
    srcIn = '0;
    wr(A_PEND, 16'hFFFF);

    // R6 zero bits ignored, ack wins, re-arm
    srcIn = 16'h0005;
    tick();
    rd(A_PEND, d); chk("R6 setup", d, 16'h0005);
    wr(A_PEND, 16'h0000);
    rd(A_PEND, d); chk("R6 zero ack", d, 16'h0005);
    wr(A_PEND, 16'h0001);
    rd(A_PEND, d); chk("R6 ack wins", d, 16'h0004);
    tick();
    rd(A_PEND, d); chk("R6 re-arm", d, 16'h0005);
    srcIn = '0;
    wr(A_PEND, 16'hFFFF);
    rd(A_PEND, d); chk("R6 ack all", d, 16'h0);

    // R8 priority over rotated patterns
    for (int k = 0; k < 16; k++) begin
      pat = (16'hA5C4 << k) | (16'hA5C4 >> (16 - k));
      msk = (16'h3C5A << k) | (16'h3C5A >> (16 - k));
      if (k == 5) msk = 16'h0000;
      wr(A_MKC, 16'hFFFF);
      wr(A_PEND, 16'hFFFF);
      srcIn = pat;
      tick();
      srcIn = '0;
      wr(A_MKS, msk);
      rd(A_PRIO, d); chk("R8 pattern", d, lowest(pat & msk));
      tick();
      chk("R7 pattern irq", {15'h0, irqOut}, {15'h0, |(pat & msk)});
    end

    finishRun();
  end

endmodule